// File: doc/BRIEF.md
# Fine/Coarse Precision Time-of-Day Counter

This block keeps a running time of day as a 32-bit seconds count and a 31-bit binary subsecond count. In this format 2^31 subsecond counts make one second, so one subsecond step is about 0.466 ns. Each update event adds a programmable 8-bit step to the subsecond count. For example, a step of about 43 gives a tick of roughly 20 ns. When the subsecond count crosses the one-second boundary, it wraps and the seconds count rises by one in the same edge.

In coarse mode an update event happens on every clock. In fine mode a 32-bit addend is summed into a 32-bit accumulator on every clock. An update event happens only on the cycles where that sum carries out of bit 31, so software sets the effective rate through the addend. A seed strobe loads both counts and clears the accumulator. A read strobe captures the live seconds and subseconds together into a pair of shadow words, so that software reads a coherent pair even when a carry occurs between its two word reads.

Top module: `tod_clock`

## Requirements
- R1: After reset the live seconds, live subseconds, low shadow word and high shadow word are all zero.
- R2: In coarse mode (fine_mode = 0), each rising clock edge adds sub_inc to the subsecond count.
- R3: The subsecond count wraps modulo 2^31. The edge on which it wraps also adds one to the seconds count. The seconds count wraps modulo 2^32.
- R4: In fine mode (fine_mode = 1), each edge adds addend to the 32-bit accumulator and keeps the low 32 bits of the sum. The counts advance by sub_inc only on edges where that sum carries out of bit 31. An addend of zero therefore never advances the counts.
- R5: On an edge where seed_stb is high, the seconds count loads seed_sec and the subsecond count loads seed_sub. The same edge clears the accumulator. The load takes precedence over any update event in that cycle.
- R6: On an edge where rd_stb is high, low_word captures {1'b0, live subseconds} and high_word captures the live seconds from before that edge. Both words then hold until the next rd_stb.
- R7: Bit 31 of low_word always reads zero.
- R8: Changes to fine_mode, sub_inc and addend take effect from the next edge. The accumulator holds its value while in coarse mode, so switching modes leaves its contents undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fine_mode | input | 1 | 1 = update on accumulator carry, 0 = update every clock |
| sub_inc | input | 8 | Subsecond step added per update event |
| addend | input | 32 | Value summed into the rate accumulator each clock in fine mode |
| seed_stb | input | 1 | Load seed values and clear the accumulator |
| seed_sec | input | 32 | Seconds value to load |
| seed_sub | input | 31 | Subseconds value to load |
| rd_stb | input | 1 | Capture the live pair into the shadow words |
| sec_now | output | 32 | Live seconds count |
| sub_now | output | 31 | Live subsecond count |
| low_word | output | 32 | Captured subseconds, bit 31 zero |
| high_word | output | 32 | Captured seconds |

## Verification
Two pairs of functions can land on the same edge, and the bench provokes both. In the first pair, a capture strobe is raised in the cycle where the subsecond count sits exactly one step below the one-second boundary. The test then checks that the shadow words hold the pre-carry pair while the live seconds have already moved on. In the second pair, a seed strobe arrives while coarse updates are running, or while the fine accumulator is half full. The test then checks that the counts equal the seeds exactly and that the next fine-mode carry comes a full addend period later.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic {
        TICK_COARSE = 1'b0,
        TICK_FINE   = 1'b1
    } tick_mode_e;
endpackage

// File: rtl/tod_rate_gen.sv
module tod_rate_gen
    import tod_pkg::*;
#(
    parameter int ADD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tick_mode_e       mode,
    input  logic [ADD_W-1:0] addend,
    input  logic             clr,
    output logic             tick
);
    typedef struct packed {
        logic [ADD_W-1:0] acc;
    } rate_st_t;

    rate_st_t     st_d, st_q;
    logic [ADD_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {1'b0, addend};
        tick = (mode == TICK_COARSE) ? 1'b1 : sum[ADD_W];
        if (clr)
            st_d.acc = '0;
        else if (mode == TICK_FINE)
            st_d.acc = sum[ADD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: accumulator contents survive coarse-mode cycles
    a_r8_acc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TICK_COARSE && !clr) |=> $stable(st_q.acc));
    // R5: the seed strobe empties the accumulator
    a_r5_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.acc == '0));
endmodule

// File: rtl/tod_core.sv
module tod_core #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [INC_W-1:0] inc,
    input  logic             load,
    input  logic [SEC_W-1:0] seed_sec,
    input  logic [SUB_W-1:0] seed_sub,
    output logic [SEC_W-1:0] sec,
    output logic [SUB_W-1:0] sub
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } tod_st_t;

    tod_st_t        st_d, st_q;
    logic [SUB_W:0] sub_sum;

    always_comb begin
        st_d    = st_q;
        sub_sum = {1'b0, st_q.sub} + (SUB_W+1)'(inc);
        if (load) begin
            st_d.sec = seed_sec;
            st_d.sub = seed_sub;
        end else if (tick) begin
            st_d.sub = sub_sum[SUB_W-1:0];
            st_d.sec = st_q.sec + SEC_W'(sub_sum[SUB_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec = st_q.sec;
    assign sub = st_q.sub;

    // R5: seeds load regardless of a concurrent update event
    a_r5_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sec == $past(seed_sec) && sub == $past(seed_sub)));
    // R4: without an update event nothing moves
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> ($stable(sec) && $stable(sub)));
    // R3: seconds only ever step by one on an update
    a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick) |=> (sec == $past(sec) || sec == $past(sec) + 1'b1));
endmodule

// File: rtl/tod_read_latch.sv
module tod_read_latch #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic [SEC_W-1:0] sec_in,
    input  logic [SUB_W-1:0] sub_in,
    output logic [SEC_W-1:0] hi,
    output logic [SUB_W:0]   lo
);
    typedef struct packed {
        logic [SEC_W-1:0] hi;
        logic [SUB_W:0]   lo;
    } shadow_st_t;

    shadow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.hi = sec_in;
            st_d.lo = {1'b0, sub_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi = st_q.hi;
    assign lo = st_q.lo;

    // R6: the pair comes from one and the same cycle
    a_r6_pair_latched: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (hi == $past(sec_in) && lo[SUB_W-1:0] == $past(sub_in)));
    // R6: shadow words hold between strobes
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ($stable(hi) && $stable(lo)));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31,
    parameter int INC_W = 8,
    parameter int ADD_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fine_mode,
    input  logic [INC_W-1:0]   sub_inc,
    input  logic [ADD_W-1:0]   addend,
    input  logic               seed_stb,
    input  logic [SEC_W-1:0]   seed_sec,
    input  logic [SUB_W-1:0]   seed_sub,
    input  logic               rd_stb,
    output logic [SEC_W-1:0]   sec_now,
    output logic [SUB_W-1:0]   sub_now,
    output logic [SUB_W:0]     low_word,
    output logic [SEC_W-1:0]   high_word
);
    localparam int LOW_W = SUB_W + 1;

    tick_mode_e mode;
    logic       tick;

    assign mode = fine_mode ? TICK_FINE : TICK_COARSE;

    tod_rate_gen #(.ADD_W(ADD_W)) i_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .addend (addend),
        .clr    (seed_stb),
        .tick   (tick)
    );

    tod_core #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .inc      (sub_inc),
        .load     (seed_stb),
        .seed_sec (seed_sec),
        .seed_sub (seed_sub),
        .sec      (sec_now),
        .sub      (sub_now)
    );

    tod_read_latch #(.SEC_W(SEC_W), .SUB_W(SUB_W)) i_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (rd_stb),
        .sec_in (sec_now),
        .sub_in (sub_now),
        .hi     (high_word),
        .lo     (low_word)
    );

    // R2: coarse mode advances the subseconds by the step on every edge
    a_r2_coarse_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!fine_mode && !seed_stb) |=>
            (sub_now == SUB_W'($past(sub_now) + SUB_W'($past(sub_inc)))));
    // R7: sign bit of the low word never set
    a_r7_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
        low_word[LOW_W-1] == 1'b0);
endmodule

// File: tb/test_tod_clock.sv
`timescale 1ns/1ps
module test_tod_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fine_mode = 1'b0;
    logic [7:0]  sub_inc = 8'd0;
    logic [31:0] addend = 32'd0;
    logic        seed_stb = 1'b0;
    logic [31:0] seed_sec = 32'd0;
    logic [30:0] seed_sub = 31'd0;
    logic        rd_stb = 1'b0;
    logic [31:0] sec_now;
    logic [30:0] sub_now;
    logic [31:0] low_word;
    logic [31:0] high_word;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [30:0] SUB_TOP = 31'h7FFF_FFFF;

    tod_clock i_tod_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .fine_mode (fine_mode),
        .sub_inc   (sub_inc),
        .addend    (addend),
        .seed_stb  (seed_stb),
        .seed_sec  (seed_sec),
        .seed_sub  (seed_sub),
        .rd_stb    (rd_stb),
        .sec_now   (sec_now),
        .sub_now   (sub_now),
        .low_word  (low_word),
        .high_word (high_word)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic seed(input logic [31:0] s, input logic [30:0] f);
        seed_sec = s;
        seed_sub = f;
        seed_stb = 1'b1;
        step(1);
        seed_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 sec", 64'(sec_now), 64'd0);
        chk("R1 sub", 64'(sub_now), 64'd0);
        chk("R1 low", 64'(low_word), 64'd0);
        chk("R1 high", 64'(high_word), 64'd0);
    endtask

    task automatic t_coarse;
        fine_mode = 1'b0;
        sub_inc = 8'd43;
        seed(32'd5, 31'd1000);
        chk("R5 seed sub", 64'(sub_now), 64'd1000);
        step(7);
        chk("R2 sub after 7", 64'(sub_now), 64'(1000 + 7 * 43));
        chk("R2 sec unchanged", 64'(sec_now), 64'd5);
        sub_inc = 8'd1;
        step(1);
        chk("R8 new inc", 64'(sub_now), 64'(1000 + 7 * 43 + 1));
    endtask

    task automatic t_wrap;
        fine_mode = 1'b0;
        sub_inc = 8'd43;
        seed(32'd7, SUB_TOP - 31'd9);
        step(1);
        chk("R3 sub wrapped", 64'(sub_now), 64'd33);
        chk("R3 sec carried", 64'(sec_now), 64'd8);
        seed(32'd7, SUB_TOP - 31'd42);
        step(1);
        chk("R3 exact boundary sub", 64'(sub_now), 64'd0);
        chk("R3 exact boundary sec", 64'(sec_now), 64'd8);
        seed(32'hFFFF_FFFF, SUB_TOP);
        step(1);
        chk("R3 sec rollover", 64'(sec_now), 64'd0);
        chk("R3 sub after rollover", 64'(sub_now), 64'd42);
    endtask

    task automatic t_fine;
        fine_mode = 1'b1;
        sub_inc = 8'd10;
        addend = 32'h8000_0000;
        seed(32'd1, 31'd100);
        step(4);
        chk("R4 half addend", 64'(sub_now), 64'd120);
        addend = 32'h4000_0000;
        step(8);
        chk("R4 quarter addend", 64'(sub_now), 64'd140);
        addend = 32'd0;
        step(5);
        chk("R4 zero addend", 64'(sub_now), 64'd140);
        addend = 32'hFFFF_FFFF;
        step(4);
        chk("R4 max addend", 64'(sub_now), 64'd170);
        chk("R4 sec stable", 64'(sec_now), 64'd1);
    endtask

    task automatic t_seed_clears_acc;
        fine_mode = 1'b1;
        sub_inc = 8'd10;
        addend = 32'h8000_0000;
        seed(32'd2, 31'd0);
        step(1);
        chk("R4 no carry yet", 64'(sub_now), 64'd0);
        seed(32'd3, 31'd500);
        chk("R5 seed over half acc", 64'(sub_now), 64'd500);
        step(1);
        chk("R5 acc cleared", 64'(sub_now), 64'd500);
        step(1);
        chk("R5 carry after full period", 64'(sub_now), 64'd510);
    endtask

    task automatic t_seed_priority;
        fine_mode = 1'b0;
        sub_inc = 8'd43;
        seed(32'd11, 31'd200);
        chk("R5 priority sub", 64'(sub_now), 64'd200);
        chk("R5 priority sec", 64'(sec_now), 64'd11);
    endtask

    task automatic t_mode_switch;
        fine_mode = 1'b1;
        sub_inc = 8'd10;
        addend = 32'h8000_0000;
        seed(32'd4, 31'd0);
        step(1);
        chk("R8 fine half", 64'(sub_now), 64'd0);
        fine_mode = 1'b0;
        step(3);
        chk("R8 coarse leg", 64'(sub_now), 64'd30);
        fine_mode = 1'b1;
        step(1);
        chk("R8 acc preserved", 64'(sub_now), 64'd40);
    endtask

    task automatic t_shadow;
        fine_mode = 1'b0;
        sub_inc = 8'd43;
        seed(32'd9, SUB_TOP - 31'd42);
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
        chk("R6 high pre-carry", 64'(high_word), 64'd9);
        chk("R6 low pre-carry", 64'(low_word), 64'({1'b0, SUB_TOP - 31'd42}));
        chk("R3 live sec moved", 64'(sec_now), 64'd10);
        chk("R7 sign clear", 64'(low_word[31]), 64'd0);
        step(3);
        chk("R6 high held", 64'(high_word), 64'd9);
        chk("R6 low held", 64'(low_word), 64'({1'b0, SUB_TOP - 31'd42}));
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        step(2);
        t_reset;
        t_coarse;
        t_wrap;
        t_fine;
        t_seed_clears_acc;
        t_seed_priority;
        t_mode_switch;
        t_shadow;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule